// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's load/store path and supplies the bookkeeping for lock-free atomic sequences built from a load-linked (LL) and a later store-conditional (SC). When an LL is issued, the monitor captures the word address into a link register and arms a reservation. When an SC is issued, the monitor decides in the same cycle whether the store may reach memory. It grants the store only if the reservation is still armed and the SC's word address equals the captured one. The outcome goes back to the core as a success bit.

Three kinds of event cancel an armed reservation. The first is a snoop invalidation that hits the cache block holding the linked word, caused by another processor's store. The other two are a taken interrupt and a context switch. Snoops are compared at block granularity, and the block size is a parameter. Every SC clears the reservation, whether it wins or loses. Plain loads and plain stores pass through and leave the reservation alone. Plain stores always get a memory write enable.

Top module: `resv_monitor`

## Requirements
- R1: After reset no reservation exists, so an SC to any address (including address 0) reports `sc_ok`=0 and `mem_wr_en`=0.
- R2: An LL (`op_kind`=2'b01 with `op_valid`) arms a reservation on `op_addr`. A later SC (`op_kind`=2'b10) to the identical word address, with no cancel in between, reports `sc_ok`=1 and `mem_wr_en`=1 in its own cycle.
- R3: An SC whose word address differs from the linked one reports `sc_ok`=0 and `mem_wr_en`=0. This holds even when the two addresses lie in the same block.
- R4: Every SC clears the reservation from the next cycle on, whether it succeeds or fails.
- R5: A new LL replaces any earlier reservation, so only its own address can then succeed.
- R6: `snoop_inv` cancels the reservation when `snoop_addr` and the linked address agree in all bits above the low `BLK_W` bits. A snoop to a different block has no effect.
- R7: `irq_taken` cancels the reservation.
- R8: `ctx_switch` cancels the reservation.
- R9: A cancel that falls in the same cycle as an SC wins. The cancel can be a snoop hit on the linked block, an interrupt or a context switch. The SC then reports `sc_ok`=0 and `mem_wr_en`=0.
- R10: An LL in the same cycle as an interrupt, a context switch, or a snoop invalidation of the LL's own block leaves no reservation.
- R11: A plain store (`op_kind`=2'b11) drives `mem_wr_en`=1. Plain loads (2'b00) and plain stores do not change the reservation. With `op_valid`=0, `op_kind` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A memory operation is issued this cycle |
| op_kind | input | 2 | 00 load, 01 load-linked, 10 store-conditional, 11 store |
| op_addr | input | AW | Word address of the operation |
| snoop_inv | input | 1 | Invalidation from another processor's store |
| snoop_addr | input | AW | Word address carried by the invalidation |
| irq_taken | input | 1 | An interrupt is taken this cycle |
| ctx_switch | input | 1 | A context switch happens this cycle |
| sc_ok | output | 1 | Store-conditional success flag (combinational) |
| mem_wr_en | output | 1 | Write enable forwarded to memory (combinational) |

## Verification
The collision of interest is an SC arriving in the same cycle as a snoop invalidation of the linked block. Interrupts and context switches raise the same race. Directed cases arm an LL and then issue the SC with a same-block snoop, an other-block snoop, an interrupt, and a context switch in that cycle. A same-block, different-word snoop must still kill the SC, while the other-block snoop must leave it successful. The constrained random phase draws addresses from four small blocks, so such collisions occur often. A bench reference model settles the cancel-before-success order and predicts `sc_ok` and `mem_wr_en` for every cycle.

// File: rtl/resv_pkg.sv
// Package: shared operation encoding for the reservation monitor.
// Assumes op_kind is only meaningful while op_valid is high.
package resv_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_LL    = 2'b01,
        OP_SC    = 2'b10,
        OP_STORE = 2'b11
    } mem_op_e;
endpackage

// File: rtl/resv_addr_cmp.sv
// Module: address comparator used for both word and block matches.
// BLOCK_GRAN=1 ignores the low BLK_W offset bits, BLOCK_GRAN=0 compares
// the full word address. Purely combinational.
module resv_addr_cmp #(
    parameter int AW         = 32,
    parameter int BLK_W      = 2,
    parameter bit BLOCK_GRAN = 1'b1
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic          hit
);
    localparam logic [AW-1:0] OFS_MASK = AW'((64'd1 << BLK_W) - 64'd1);

    generate
        if (BLOCK_GRAN) begin : g_block
            // Compare only the block tag bits.
            assign hit = (((a ^ b) & ~OFS_MASK) == '0);
        end else begin : g_word
            // Compare every address bit.
            assign hit = (a == b);
        end
    endgenerate
endmodule

// File: rtl/resv_link_reg.sv
// Module: link register holding the reserved address and its valid bit.
// Clear has priority over set. The caller guarantees that a set is never
// meant to survive a clear issued in the same cycle.
module resv_link_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [AW-1:0] set_addr,
    input  logic          clr_en,
    output logic          link_valid,
    output logic [AW-1:0] link_addr
);
    // Track reservation validity.
    always_ff @(posedge clk) begin
        if (!rst_n)      link_valid <= 1'b0;
        else if (clr_en) link_valid <= 1'b0;
        else if (set_en) link_valid <= 1'b1;
    end

    // Capture the linked address on every accepted set.
    always_ff @(posedge clk) begin
        if (!rst_n)                link_addr <= '0;
        else if (set_en && !clr_en) link_addr <= set_addr;
    end

    p_set_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=> (link_valid && link_addr == $past(set_addr)));
    p_clear_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !link_valid);
endmodule

// File: rtl/resv_monitor.sv
// Module: top of the reservation monitor. It decodes the issued operation,
// judges SC success against the link register, and applies cancel events.
// Assumes one operation per cycle; snoop, interrupt and context-switch
// inputs are single-cycle pulses aligned to clk.
module resv_monitor
    import resv_pkg::*;
#(
    parameter int AW    = 32,
    parameter int BLK_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic          snoop_inv,
    input  logic [AW-1:0] snoop_addr,
    input  logic          irq_taken,
    input  logic          ctx_switch,
    output logic          sc_ok,
    output logic          mem_wr_en
);
    logic          is_ll, is_sc, is_st;
    logic          link_valid;
    logic [AW-1:0] link_addr;
    logic          word_hit, snp_cur_hit, snp_new_hit;
    logic          cancel_cur, cancel_new;
    logic          set_en, clr_en;

    // Decode the issued operation.
    always_comb begin
        is_ll = op_valid && (mem_op_e'(op_kind) == OP_LL);
        is_sc = op_valid && (mem_op_e'(op_kind) == OP_SC);
        is_st = op_valid && (mem_op_e'(op_kind) == OP_STORE);
    end

    resv_addr_cmp #(.AW(AW), .BLK_W(BLK_W), .BLOCK_GRAN(1'b0)) i_word_cmp (
        .a(op_addr), .b(link_addr), .hit(word_hit));
    resv_addr_cmp #(.AW(AW), .BLK_W(BLK_W), .BLOCK_GRAN(1'b1)) i_snp_cur_cmp (
        .a(snoop_addr), .b(link_addr), .hit(snp_cur_hit));
    resv_addr_cmp #(.AW(AW), .BLK_W(BLK_W), .BLOCK_GRAN(1'b1)) i_snp_new_cmp (
        .a(snoop_addr), .b(op_addr), .hit(snp_new_hit));

    // Cancel conditions against the held and against an incoming reservation.
    always_comb begin
        cancel_cur = irq_taken || ctx_switch || (snoop_inv && snp_cur_hit);
        cancel_new = irq_taken || ctx_switch || (snoop_inv && snp_new_hit);
    end

    // SC verdict and memory write enable; cancels take priority.
    always_comb begin
        sc_ok     = is_sc && link_valid && word_hit && !cancel_cur;
        mem_wr_en = is_st || sc_ok;
    end

    // Link register control.
    always_comb begin
        set_en = is_ll && !cancel_new;
        clr_en = is_sc || (is_ll && cancel_new) || (!is_ll && cancel_cur);
    end

    resv_link_reg #(.AW(AW)) i_link (
        .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_addr(op_addr),
        .clr_en(clr_en), .link_valid(link_valid), .link_addr(link_addr));

    p_sc_needs_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> (link_valid && op_addr == link_addr));
    p_fail_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && !sc_ok) |-> !mem_wr_en);
    p_sc_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_sc |=> !link_valid);
    p_irq_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_taken && !is_ll) |=> !link_valid);
    p_ctx_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_switch |=> !link_valid);
    p_snoop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && snoop_inv && snp_cur_hit) |-> !sc_ok);
    p_store_writes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_st |-> mem_wr_en);
endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int BLK_W = 2;
    localparam logic [1:0] K_LD = 2'b00, K_LL = 2'b01, K_SC = 2'b10, K_ST = 2'b11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [1:0] op_kind = 2'b00;
    logic [AW-1:0] op_addr = '0, snoop_addr = '0;
    logic snoop_inv = 1'b0, irq_taken = 1'b0, ctx_switch = 1'b0;
    logic sc_ok, mem_wr_en;

    int checks = 0, errors = 0;
    logic ref_valid = 1'b0;
    logic [AW-1:0] ref_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_monitor #(.AW(AW), .BLK_W(BLK_W)) i_resv_monitor (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .snoop_inv(snoop_inv), .snoop_addr(snoop_addr),
        .irq_taken(irq_taken), .ctx_switch(ctx_switch),
        .sc_ok(sc_ok), .mem_wr_en(mem_wr_en));

    function automatic logic same_blk(logic [AW-1:0] a, logic [AW-1:0] b);
        return (a >> BLK_W) == (b >> BLK_W);
    endfunction

    function automatic logic exp_ok(logic v, logic [1:0] k, logic [AW-1:0] a,
                                    logic inv, logic [AW-1:0] sa, logic irq, logic cs);
        logic cancel = irq || cs || (inv && same_blk(sa, ref_addr));
        return v && k == K_SC && ref_valid && a == ref_addr && !cancel;
    endfunction

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check settled outputs, advance the model.
    task automatic step(string tag, logic v, logic [1:0] k, logic [AW-1:0] a,
                        logic inv = 1'b0, logic [AW-1:0] sa = '0,
                        logic irq = 1'b0, logic cs = 1'b0);
        logic eo, cn_cur, cn_new;
        @(negedge clk);
        op_valid = v; op_kind = k; op_addr = a;
        snoop_inv = inv; snoop_addr = sa; irq_taken = irq; ctx_switch = cs;
        #1;
        eo = exp_ok(v, k, a, inv, sa, irq, cs);
        check(tag, "sc_ok", sc_ok, eo);
        check(tag, "mem_wr_en", mem_wr_en, (v && k == K_ST) || eo);
        cn_cur = irq || cs || (inv && same_blk(sa, ref_addr));
        cn_new = irq || cs || (inv && same_blk(sa, a));
        if (v && k == K_SC) ref_valid = 1'b0;
        else if (v && k == K_LL) begin
            if (cn_new) ref_valid = 1'b0;
            else begin ref_valid = 1'b1; ref_addr = a; end
        end else if (cn_cur) ref_valid = 1'b0;
    endtask

    localparam logic [AW-1:0] A0 = 32'h0000_1000;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: no reservation after reset, even at address 0
        step("R1", 1, K_SC, '0);
        step("R1", 1, K_SC, A0);
        // R2: LL then matching SC succeeds
        step("R2", 1, K_LL, A0 + 5);
        step("R2", 1, K_SC, A0 + 5);
        // R4: second SC fails after clear
        step("R4", 1, K_SC, A0 + 5);
        // R3: same block, different word
        step("R3", 1, K_LL, A0 + 4);
        step("R3", 1, K_SC, A0 + 5);
        step("R4", 1, K_SC, A0 + 4);
        // R5: overwrite
        step("R5", 1, K_LL, A0 + 1);
        step("R5", 1, K_LL, A0 + 9);
        step("R5", 1, K_SC, A0 + 9);
        // R6: snoop same block different word kills, other block keeps
        step("R6", 1, K_LL, A0 + 8);
        step("R6", 0, K_SC, A0, 1'b1, A0 + 11);
        step("R6", 1, K_SC, A0 + 8);
        step("R6", 1, K_LL, A0 + 8);
        step("R6", 0, K_LD, A0, 1'b1, A0 + 12);
        step("R6", 1, K_SC, A0 + 8);
        // R7, R8
        step("R7", 1, K_LL, A0 + 2);
        step("R7", 0, K_LD, A0, 1'b0, '0, 1'b1);
        step("R7", 1, K_SC, A0 + 2);
        step("R8", 1, K_LL, A0 + 2);
        step("R8", 1, K_LD, A0 + 2, 1'b0, '0, 1'b0, 1'b1);
        step("R8", 1, K_SC, A0 + 2);
        // R9: collisions in the SC cycle
        step("R9", 1, K_LL, A0 + 6);
        step("R9", 1, K_SC, A0 + 6, 1'b1, A0 + 7);
        step("R9", 1, K_LL, A0 + 6);
        step("R9", 1, K_SC, A0 + 6, 1'b1, A0 + 13);
        step("R9", 1, K_LL, A0 + 6);
        step("R9", 1, K_SC, A0 + 6, 1'b0, '0, 1'b1);
        step("R9", 1, K_LL, A0 + 6);
        step("R9", 1, K_SC, A0 + 6, 1'b0, '0, 1'b0, 1'b1);
        // R10: LL colliding with a cancel
        step("R10", 1, K_LL, A0 + 3, 1'b1, A0 + 0);
        step("R10", 1, K_SC, A0 + 3);
        step("R10", 1, K_LL, A0 + 3, 1'b0, '0, 1'b1);
        step("R10", 1, K_SC, A0 + 3);
        step("R10", 1, K_LL, A0 + 3, 1'b1, A0 + 14);
        step("R10", 1, K_SC, A0 + 3);
        // R11: plain ops and invalid op leave the reservation
        step("R11", 1, K_LL, A0 + 10);
        step("R11", 1, K_ST, A0 + 10);
        step("R11", 1, K_LD, A0 + 10);
        step("R11", 0, K_SC, A0 + 10);
        step("R11", 1, K_SC, A0 + 10);
        // Random mix exercising R2 R3 R6 R9 together
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] k = 2'($urandom % 4);
            step("R2/R3/R6/R9 random", ($urandom % 8) != 0, k,
                 A0 + ($urandom % 16), ($urandom % 6) == 0, A0 + ($urandom % 16),
                 ($urandom % 25) == 0, ($urandom % 25) == 0);
        end
        step("end", 0, K_LD, '0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule